// File: doc/BRIEF.md
# Element Loop Issue Sequencer

The sequencer takes one scalar instruction at a time and issues it again as a run of internal micro-operations, one for each vector element. The number of elements comes from a vector-length setting. Element `e` of the run uses each of the instruction's register numbers plus `e`. A vector length of one gives a single micro-operation with the register numbers unchanged.

Each element has its own carry bit, held in a small carry bank. Element `e` reads carry bit `e`. Execution units write the carry results back on a separate port indexed by element. The whole bank can also be read and written as one register, so a context switch can save it and put it back.

While a run is in progress, the condition-field selector on each micro-operation points at field 6. A single-issue instruction targets field 0. `rst_n` is an asynchronous active-low reset. The clock domain must synchronise its release before it reaches the block.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `uop_valid` is 0 and `csr_rdata` is all zeros.
- R2: An instruction accepted with an effective vector length `n` produces exactly `n` micro-operations, in element order `uop_elem` = 0 to n-1. `uop_last` is 1 only on element n-1.
- R3: On element `e`, `uop_dst`, `uop_src_a` and `uop_src_b` equal the accepted register numbers plus `e`, taken modulo 2^REG_W, so number 31 steps to 0.
- R4: `vec_len` is sampled only when an instruction is accepted. A value of 0 acts as 1 and a value above MAX_VL (8) acts as 8. A change to `vec_len` during a run has no effect on that run.
- R5: `in_ready` is 0 from the cycle after acceptance until the final element is taken. It returns to 1 in the cycle after that.
- R6: While `uop_valid` is 1 and `uop_ready` is 0, every micro-operation output holds its value and the element count does not advance.
- R7: `uop_carry_in` equals carry bit `uop_elem` of the bank. `uop_carry_use` repeats the accepted carry-use flag on every element.
- R8: A carry write with `cw_en` = 1 sets bit `cw_idx` of the bank to `cw_val` and leaves the other bits unchanged. A `cw_idx` of MAX_VL or above changes nothing.
- R9: A `csr_we` pulse replaces the whole bank with `csr_wdata`, and `csr_rdata` always shows the bank. When a register write and a carry write occur in the same cycle, the register write wins.
- R10: `uop_cr_field` is 6 on every micro-operation of a run with effective length above 1, and 0 on a single-issue instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Scalar instruction offered |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_dst | input | REG_W | Base destination register number |
| in_src_a | input | REG_W | Base first source register number |
| in_src_b | input | REG_W | Base second source register number |
| in_carry_use | input | 1 | Instruction consumes or produces a carry |
| vec_len | input | VL_W | Vector-length setting |
| uop_valid | output | 1 | Micro-operation offered |
| uop_ready | input | 1 | Downstream takes the micro-operation |
| uop_dst | output | REG_W | Destination register number for this element |
| uop_src_a | output | REG_W | First source register number for this element |
| uop_src_b | output | REG_W | Second source register number for this element |
| uop_elem | output | IDX_W | Element index |
| uop_last | output | 1 | Final element of the run |
| uop_carry_use | output | 1 | Carry-use flag of the instruction |
| uop_carry_in | output | 1 | Carry bit belonging to this element |
| uop_cr_field | output | 3 | Condition field to update |
| cw_en | input | 1 | Carry result write enable |
| cw_idx | input | VL_W | Element whose carry bit is written |
| cw_val | input | 1 | Carry value written |
| csr_we | input | 1 | Whole-bank register write |
| csr_wdata | input | MAX_VL | Bank value written |
| csr_rdata | output | MAX_VL | Current carry bank |

## Verification
A wrong element counter shows up at once, in the same cycle, as a wrong `uop_elem` and wrong register numbers. It can also show as a missing or extra `uop_last`, which leaves `in_ready` low or raises it one element early. A stale latched vector length shows only at the end of a run, when the count of micro-operations differs from the expected count. A bad carry bank entry stays hidden until an element with that index is issued, or until `csr_rdata` is read. For that reason the reference model compares the full bank on every cycle, and does not wait for an issue to expose it.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_t;

  localparam logic [2:0] CR_FIELD_SCALAR = 3'd0;
  localparam logic [2:0] CR_FIELD_VECTOR = 3'd6;
endpackage

// File: rtl/elem_vl_clamp.sv
module elem_vl_clamp #(
  parameter int MAX_VL = 8,
  parameter int VL_W   = 4,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic [VL_W-1:0]  vl_raw,
  output logic [IDX_W-1:0] last_idx
);
  // Turns a length setting into the index of the final element.
  always_comb begin
    if (vl_raw == '0) begin
      last_idx = '0;
    end else if (int'(vl_raw) > MAX_VL) begin
      last_idx = IDX_W'(MAX_VL - 1);
    end else begin
      last_idx = IDX_W'(vl_raw - 1'b1);
    end
  end
endmodule

// File: rtl/elem_issue_ctrl.sv
module elem_issue_ctrl
  import elem_loop_pkg::*;
#(
  parameter int MAX_VL = 8,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] last_idx_in,
  input  logic             out_ready,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] elem,
  output logic             is_last,
  output logic             multi
);
  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] elem_q, elem_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             fire;
  logic             ctl_en;

  assign accept = (state_q == SEQ_IDLE) && in_valid;
  assign fire   = (state_q == SEQ_ISSUE) && out_ready;
  assign ctl_en = accept || fire;

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    last_d  = last_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (in_valid) begin
          state_d = SEQ_ISSUE;
          elem_d  = '0;
          last_d  = last_idx_in;
        end
      end
      SEQ_ISSUE: begin
        if (out_ready) begin
          if (elem_q == last_q) begin
            state_d = SEQ_IDLE;
          end else begin
            elem_d = elem_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      elem_q  <= '0;
      last_q  <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      elem_q  <= elem_d;
      last_q  <= last_d;
    end
  end

  assign busy    = (state_q == SEQ_ISSUE);
  assign elem    = elem_q;
  assign is_last = (elem_q == last_q);
  assign multi   = (last_q != '0);
endmodule

// File: rtl/elem_carry_bank.sv
module elem_carry_bank #(
  parameter int MAX_VL = 8,
  parameter int VL_W   = 4,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_en,
  input  logic [VL_W-1:0]   cw_idx,
  input  logic              cw_val,
  input  logic              csr_we,
  input  logic [MAX_VL-1:0] csr_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit,
  output logic [MAX_VL-1:0] bank
);
  logic [MAX_VL-1:0] bank_q, bank_d;
  logic              bank_en;

  // Each bit has its own update term; the whole-register write overrides it.
  for (genvar g = 0; g < MAX_VL; g++) begin : g_bit
    logic hit;
    assign hit = cw_en && (int'(cw_idx) == g);
    always_comb begin
      if (csr_we)   bank_d[g] = csr_wdata[g];
      else if (hit) bank_d[g] = cw_val;
      else          bank_d[g] = bank_q[g];
    end
  end

  assign bank_en = csr_we || cw_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_en) begin
      bank_q <= bank_d;
    end
  end

  assign rd_bit = bank_q[rd_idx];
  assign bank   = bank_q;
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import elem_loop_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int MAX_VL = 8,
  parameter int VL_W   = 4,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src_a,
  input  logic [REG_W-1:0]  in_src_b,
  input  logic              in_carry_use,
  input  logic [VL_W-1:0]   vec_len,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [REG_W-1:0]  uop_dst,
  output logic [REG_W-1:0]  uop_src_a,
  output logic [REG_W-1:0]  uop_src_b,
  output logic [IDX_W-1:0]  uop_elem,
  output logic              uop_last,
  output logic              uop_carry_use,
  output logic              uop_carry_in,
  output logic [2:0]        uop_cr_field,
  input  logic              cw_en,
  input  logic [VL_W-1:0]   cw_idx,
  input  logic              cw_val,
  input  logic              csr_we,
  input  logic [MAX_VL-1:0] csr_wdata,
  output logic [MAX_VL-1:0] csr_rdata
);
  localparam int NOPS = 3;

  logic [IDX_W-1:0] last_idx_in;
  logic             accept;
  logic             busy;
  logic [IDX_W-1:0] elem;
  logic             multi;

  elem_vl_clamp #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_clamp (
    .vl_raw   (vec_len),
    .last_idx (last_idx_in)
  );

  elem_issue_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .last_idx_in (last_idx_in),
    .out_ready   (uop_ready),
    .accept      (accept),
    .busy        (busy),
    .elem        (elem),
    .is_last     (uop_last),
    .multi       (multi)
  );

  elem_carry_bank #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_carry (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_en     (cw_en),
    .cw_idx    (cw_idx),
    .cw_val    (cw_val),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .rd_idx    (elem),
    .rd_bit    (uop_carry_in),
    .bank      (csr_rdata)
  );

  // Operand base registers, captured on acceptance.
  logic [REG_W-1:0] base_in [NOPS];
  logic [REG_W-1:0] base_q  [NOPS];
  logic [REG_W-1:0] step    [NOPS];
  logic             cuse_q;

  assign base_in[0] = in_dst;
  assign base_in[1] = in_src_a;
  assign base_in[2] = in_src_b;

  for (genvar k = 0; k < NOPS; k++) begin : g_opnd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[k] <= '0;
      end else if (accept) begin
        base_q[k] <= base_in[k];
      end
    end
    assign step[k] = base_q[k] + REG_W'(elem);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cuse_q <= 1'b0;
    end else if (accept) begin
      cuse_q <= in_carry_use;
    end
  end

  assign in_ready      = !busy;
  assign uop_valid     = busy;
  assign uop_dst       = step[0];
  assign uop_src_a     = step[1];
  assign uop_src_b     = step[2];
  assign uop_elem      = elem;
  assign uop_carry_use = cuse_q;
  assign uop_cr_field  = multi ? CR_FIELD_VECTOR : CR_FIELD_SCALAR;
endmodule

// File: rtl/elem_loop_seq_chk.sv
module elem_loop_seq_chk #(
  parameter int REG_W  = 5,
  parameter int MAX_VL = 8,
  parameter int VL_W   = 4,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              uop_valid,
  input logic              uop_ready,
  input logic [REG_W-1:0]  uop_dst,
  input logic [REG_W-1:0]  uop_src_a,
  input logic [REG_W-1:0]  uop_src_b,
  input logic [IDX_W-1:0]  uop_elem,
  input logic              uop_last,
  input logic [2:0]        uop_cr_field,
  input logic              cw_en,
  input logic [VL_W-1:0]   cw_idx,
  input logic              csr_we,
  input logic [MAX_VL-1:0] csr_wdata,
  input logic [MAX_VL-1:0] csr_rdata
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !uop_valid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_dst) && $stable(uop_src_a)
                                   && $stable(uop_src_b) && $stable(uop_elem))); // R6

  AST_REG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && !uop_last) |=>
      (uop_valid && uop_dst == REG_W'($past(uop_dst) + 1'b1)
       && uop_elem == IDX_W'($past(uop_elem) + 1'b1))); // R3

  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_ready && uop_last) |=> (in_ready && !uop_valid)); // R2

  AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> (int'(uop_elem) < MAX_VL)); // R4

  AST_CSR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (csr_rdata == $past(csr_wdata))); // R9

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && int'(cw_idx) >= MAX_VL && !csr_we) |=> $stable(csr_rdata)); // R8

  AST_CR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_elem != '0) |-> (uop_cr_field == 3'd6)); // R10
endmodule

bind elem_loop_seq elem_loop_seq_chk #(.REG_W(REG_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_chk (.*);

// File: tb/tb_elem_loop_seq.sv
module tb_elem_loop_seq;
  localparam int REG_W  = 5;
  localparam int MAX_VL = 8;
  localparam int VL_W   = 4;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [REG_W-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic in_carry_use = 1'b0;
  logic [VL_W-1:0] vec_len = 4'd1;
  logic uop_valid;
  logic uop_ready = 1'b1;
  logic [REG_W-1:0] uop_dst, uop_src_a, uop_src_b;
  logic [IDX_W-1:0] uop_elem;
  logic uop_last, uop_carry_use, uop_carry_in;
  logic [2:0] uop_cr_field;
  logic cw_en = 1'b0;
  logic [VL_W-1:0] cw_idx = '0;
  logic cw_val = 1'b0;
  logic csr_we = 1'b0;
  logic [MAX_VL-1:0] csr_wdata = '0;
  logic [MAX_VL-1:0] csr_rdata;

  always #4 clk = ~clk;  // 125 MHz

  elem_loop_seq #(.REG_W(REG_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) dut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit random_ready = 1'b0;
  bit done = 1'b0;

  // Behavioural reference model.
  int q_dst[$], q_a[$], q_b[$], q_elem[$], q_last[$];
  int m_cr = 0;
  int m_cuse = 0;
  logic [MAX_VL-1:0] m_carry = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (q_dst.size() == 0 && in_valid) begin
        int n;
        n = (vec_len == 0) ? 1 : ((int'(vec_len) > MAX_VL) ? MAX_VL : int'(vec_len));
        for (int e = 0; e < n; e++) begin
          q_dst.push_back((int'(in_dst) + e) % 32);
          q_a.push_back((int'(in_src_a) + e) % 32);
          q_b.push_back((int'(in_src_b) + e) % 32);
          q_elem.push_back(e);
          q_last.push_back(e == n - 1);
        end
        m_cr = (n > 1) ? 6 : 0;
        m_cuse = int'(in_carry_use);
      end else if (q_dst.size() > 0 && uop_ready) begin
        void'(q_dst.pop_front());
        void'(q_a.pop_front());
        void'(q_b.pop_front());
        void'(q_elem.pop_front());
        void'(q_last.pop_front());
      end
      if (csr_we) m_carry = csr_wdata;
      else if (cw_en && int'(cw_idx) < MAX_VL) m_carry[cw_idx] = cw_val;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit busy;
      busy = (q_dst.size() > 0);
      chk(in_ready == !busy, "R5 in_ready", int'(in_ready), int'(!busy));
      chk(uop_valid == busy, "R2 uop_valid", int'(uop_valid), int'(busy));
      if (busy && uop_valid) begin
        chk(int'(uop_dst) == q_dst[0], "R3/R6 uop_dst", int'(uop_dst), q_dst[0]);
        chk(int'(uop_src_a) == q_a[0], "R3 uop_src_a", int'(uop_src_a), q_a[0]);
        chk(int'(uop_src_b) == q_b[0], "R3 uop_src_b", int'(uop_src_b), q_b[0]);
        chk(int'(uop_elem) == q_elem[0], "R2/R4 uop_elem", int'(uop_elem), q_elem[0]);
        chk(int'(uop_last) == q_last[0], "R2 uop_last", int'(uop_last), q_last[0]);
        chk(uop_carry_in == m_carry[q_elem[0]], "R7 uop_carry_in",
            int'(uop_carry_in), int'(m_carry[q_elem[0]]));
        chk(int'(uop_carry_use) == m_cuse, "R7 uop_carry_use", int'(uop_carry_use), m_cuse);
        chk(int'(uop_cr_field) == m_cr, "R10 uop_cr_field", int'(uop_cr_field), m_cr);
      end
      chk(csr_rdata == m_carry, "R8/R9 csr_rdata", int'(csr_rdata), int'(m_carry));
    end
  end

  always @(negedge clk) uop_ready <= random_ready ? 1'($urandom_range(0, 1)) : 1'b1;

  task automatic issue(input int d, input int a, input int b, input bit cu, input int vl);
    bit acc;
    @(negedge clk);
    in_dst = REG_W'(d); in_src_a = REG_W'(a); in_src_b = REG_W'(b);
    in_carry_use = cu; vec_len = VL_W'(vl); in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      #1 acc = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic carry_wr(input int idx, input bit v);
    @(negedge clk);
    cw_en = 1'b1; cw_idx = VL_W'(idx); cw_val = v;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic csr_wr(input logic [MAX_VL-1:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(uop_valid == 1'b0, "R1 uop_valid", int'(uop_valid), 0);
    chk(csr_rdata == '0, "R1 csr_rdata", int'(csr_rdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(3, 4, 5, 1'b0, 1); drain();          // single pass-through, R10 field 0
    issue(30, 29, 31, 1'b1, 4); drain();       // R3 wrap past 31
    csr_wr(8'hA5);                             // R9
    issue(8, 16, 24, 1'b1, 8); drain();        // R7 carry per element
    carry_wr(2, 1'b1); carry_wr(0, 1'b0);      // R8
    carry_wr(9, 1'b1); carry_wr(8, 1'b1);      // R8 out of range ignored
    // R9 same-cycle collision: register write wins
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = 8'h0F; cw_en = 1'b1; cw_idx = 4'd1; cw_val = 1'b0;
    @(negedge clk);
    csr_we = 1'b0; cw_en = 1'b0;
    issue(1, 2, 3, 1'b0, 0); drain();          // R4 zero acts as one
    issue(10, 11, 12, 1'b0, 13); drain();      // R4 clamp to eight
    // R4: vec_len change mid-run ignored
    issue(5, 6, 7, 1'b1, 3);
    vec_len = 4'd8;
    drain();
    random_ready = 1'b1;                       // R6 back-pressure
    for (int i = 0; i < 12; i++) begin
      issue(i * 3, i * 5, i * 7, i[0], (i % 9) + 1);
      if (i % 3 == 0) carry_wr(i % 10, i[1]);
    end
    drain();
    random_ready = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule